// File: doc/BRIEF.md
# Read-Ahead Byte Stream Buffer

This block fetches a contiguous memory region ahead of its consumer and holds the bytes in a local FIFO. A fill is started with a base address and a byte length. The block cuts the region into read requests of at most `MAX_REQ` bytes. It issues them through a fixed ring of `SLOTS` request tags and accepts completions for any tag in any order. Data enters the FIFO strictly in the order the requests were issued.

Issue is credit-limited. A request goes out only when three amounts together fit in the FIFO capacity: the bytes already buffered, the bytes still in flight, and the size of the new request. Read data therefore always has room when it arrives.

A consumer pulls 1 to `GET_MAX` bytes at a time and is served only when that many bytes are present. A fill can be cut short: outstanding reads are then marked void and their data is thrown away when it returns. A quiesce input holds off new requests so that in-flight work can settle. Single-cycle pulses report end of region, return to idle and forced-read underrun.

Top module: `rd_prefetch_fifo`

## Requirements
- R1: Each request has size min(`MAX_REQ`, end address − next address) and starts where the previous one ended. Consecutive requests of one fill therefore cover the region in ascending address order with no gap.
- R2: `req_valid` is high only when all four of these hold: a tag is free, the fill has not reached its end, buffered + in-flight + new-request bytes ≤ `DEPTH`, and neither `drain_req` nor `fill_stop` is high. With defaults, an unanswered fill stops at 4 requests, and a fill whose buffer is full stops at 32 buffered bytes.
- R3: A completed request moves its data into the FIFO only once every earlier-issued request has done so. A completion that arrives early for a later tag leaves `avail` unchanged.
- R4: `fill_stop` moves the next address to the end address and marks every in-flight request void. Void data never enters the FIFO. No request is issued in the cycle `fill_stop` is high.
- R5: A read with `get_valid` and length L succeeds (`get_ok`=1) exactly when `avail` ≥ L. On success, `get_data[8*i+7:8*i]` holds the i-th oldest byte, so byte 0 is the lowest address. A successful read frees space, and issue then resumes.
- R6: `fill_start` takes effect only when `fill_ended` is 1. Otherwise it is ignored and the running fill continues at its own next address.
- R7: `eob` pulses for one cycle, in the cycle after the next address first becomes equal to the end address. This can be through the last issue or through `fill_stop`.
- R8: While `drain_req` is high no request is issued. `drained` is 1 exactly when no request is in flight.
- R9: `idle` pulses for one cycle after a retirement leaves no request in flight while the fill is at its end.
- R10: A read with `get_valid` and `get_force` that fails raises `underrun` for one cycle. A failed read without `get_force` does not.
- R11: After reset: `req_valid`=0, `avail`=0, `drained`=1, `fill_ended`=1, and `eob`, `idle` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_start | input | 1 | Start a fill (pulse) |
| fill_addr | input | ADDR_W | Base address of the fill |
| fill_len | input | ADDR_W | Byte length of the fill |
| fill_stop | input | 1 | Cut the current fill short (pulse) |
| drain_req | input | 1 | Hold off new requests |
| req_valid | output | 1 | A read request is offered |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Request start address |
| req_size | output | SZ_W | Request byte count |
| req_slot | output | SLOT_W | Tag of the request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_slot | input | SLOT_W | Tag being completed |
| cpl_data | input | 8*MAX_REQ | Completion bytes, byte 0 in bits 7:0 |
| get_valid | input | 1 | Consumer read attempt |
| get_len | input | GL_W | Bytes requested (0..GET_MAX) |
| get_force | input | 1 | Read must succeed; failure flags underrun |
| get_ok | output | 1 | Read served this cycle |
| get_data | output | 8*GET_MAX | Oldest FIFO bytes, oldest in bits 7:0 |
| avail | output | CNT_W | Bytes held in the FIFO |
| fill_ended | output | 1 | Next address equals end address |
| eob | output | 1 | End-of-region pulse |
| idle | output | 1 | Return-to-idle pulse |
| drained | output | 1 | No request in flight |
| underrun | output | 1 | Forced read failed (pulse) |

## Verification
Several invariants are checked by the assertions on every cycle. Buffered plus in-flight bytes never exceed capacity, and the in-flight count never passes the tag count. Offered requests always have a legal size, and nothing is offered once the fill has ended. A stop leaves the fill ended. A quiesced, empty engine stays empty. `idle` comes only with nothing in flight, and a failed forced read is always flagged.

Other behaviour is visible only over whole scenarios, so the bench's scenarios show it. These are the in-order retirement of out-of-order completions, and the loss of void data after a stop. They also include the address and size sequence of a fill, the byte order seen by the consumer, and a start that arrives mid-fill being ignored.

// File: rtl/pf_pkg.sv
// Shared defaults for the read-ahead buffer.
// Assumes nothing; only constants live here.
package pf_pkg;
    localparam int unsigned DEF_ADDR_W  = 16;
    localparam int unsigned DEF_MAX_REQ = 4;
    localparam int unsigned DEF_SLOTS   = 4;
    localparam int unsigned DEF_DEPTH   = 32;
    localparam int unsigned DEF_GET_MAX = 4;
endpackage

// File: rtl/pf_fill_ctrl.sv
// Fill address controller: holds next/end address, computes the size of
// the next request, applies start (only when ended), stop and issue.
// Assumes issue is never asserted while at the end or during stop.
module pf_fill_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int MAX_REQ = 4,
    parameter int SZ_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] start_len,
    input  logic              stop,
    input  logic              issue,
    output logic [ADDR_W-1:0] next_addr,
    output logic [SZ_W-1:0]   req_size,
    output logic              at_end,
    output logic              at_end_nxt
);
    logic [ADDR_W-1:0] next_q, end_q, next_n, end_n, remain;

    // Request size and next-state address selection.
    always_comb begin
        remain = end_q - next_q;
        if (remain >= ADDR_W'(MAX_REQ)) req_size = SZ_W'(MAX_REQ);
        else                             req_size = SZ_W'(remain);
        at_end = (next_q == end_q);
        next_n = next_q;
        end_n  = end_q;
        if (stop) begin
            next_n = end_q;
        end else if (start && at_end) begin
            next_n = start_addr;
            end_n  = start_addr + start_len;
        end else if (issue) begin
            next_n = next_q + ADDR_W'(req_size);
        end
        at_end_nxt = (next_n == end_n);
    end

    // Address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            end_q  <= '0;
        end else begin
            next_q <= next_n;
            end_q  <= end_n;
        end
    end

    assign next_addr = next_q;
endmodule

// File: rtl/pf_slot_track.sv
// Request tag ring: tags are allocated and retired in ring order, so the
// pending list is the span between the retire and issue pointers.
// Completions may arrive for any busy tag; only the head retires.
// Assumes completions name busy, not-yet-done tags.
module pf_slot_track #(
    parameter int SLOTS   = 4,
    parameter int MAX_REQ = 4,
    parameter int SZ_W    = 3,
    parameter int SLOT_W  = 2,
    parameter int PCNT_W  = 3,
    parameter int PB_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [SZ_W-1:0]      issue_size,
    input  logic                 cancel_all,
    input  logic                 cpl_valid,
    input  logic [SLOT_W-1:0]    cpl_slot,
    input  logic [MAX_REQ*8-1:0] cpl_data,
    output logic [SLOT_W-1:0]    iss_slot,
    output logic                 has_free,
    output logic [PCNT_W-1:0]    pend_cnt,
    output logic [PCNT_W-1:0]    pend_cnt_nxt,
    output logic [PB_W-1:0]      pend_bytes,
    output logic                 retire,
    output logic [SZ_W-1:0]      ret_size,
    output logic                 ret_keep,
    output logic [MAX_REQ*8-1:0] ret_data
);
    logic [SLOTS-1:0]       busy_q, done_q, void_q;
    logic [SZ_W-1:0]        size_q [SLOTS];
    logic [MAX_REQ*8-1:0]   data_q [SLOTS];
    logic [SLOT_W-1:0]      iss_ptr, ret_ptr;
    logic [PCNT_W-1:0]      cnt_q;

    // Head retirement and free-tag status.
    always_comb begin
        has_free     = (cnt_q < PCNT_W'(SLOTS));
        retire       = (cnt_q != '0) && done_q[ret_ptr];
        ret_size     = size_q[ret_ptr];
        ret_keep     = !void_q[ret_ptr];
        ret_data     = data_q[ret_ptr];
        pend_cnt_nxt = cnt_q + PCNT_W'(issue) - PCNT_W'(retire);
    end

    // Bytes still in flight over all busy tags.
    always_comb begin
        pend_bytes = '0;
        for (int i = 0; i < SLOTS; i++)
            if (busy_q[i]) pend_bytes = pend_bytes + PB_W'(size_q[i]);
    end

    // Per-tag state: allocate, complete, void, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            done_q <= '0;
            void_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (retire && ret_ptr == SLOT_W'(i)) begin
                    busy_q[i] <= 1'b0;
                    done_q[i] <= 1'b0;
                    void_q[i] <= 1'b0;
                end
                if (issue && iss_ptr == SLOT_W'(i)) begin
                    busy_q[i] <= 1'b1;
                    done_q[i] <= 1'b0;
                    void_q[i] <= 1'b0;
                    size_q[i] <= issue_size;
                end
                if (cpl_valid && cpl_slot == SLOT_W'(i) && busy_q[i] && !done_q[i]) begin
                    done_q[i] <= 1'b1;
                    data_q[i] <= cpl_data;
                end
                if (cancel_all && busy_q[i]) void_q[i] <= 1'b1;
            end
        end
    end

    // Ring pointers and in-flight count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_ptr <= '0;
            ret_ptr <= '0;
            cnt_q   <= '0;
        end else begin
            if (issue)  iss_ptr <= (iss_ptr == SLOT_W'(SLOTS-1)) ? '0 : iss_ptr + 1'b1;
            if (retire) ret_ptr <= (ret_ptr == SLOT_W'(SLOTS-1)) ? '0 : ret_ptr + 1'b1;
            cnt_q <= pend_cnt_nxt;
        end
    end

    assign iss_slot = iss_ptr;
    assign pend_cnt = cnt_q;
endmodule

// File: rtl/pf_byte_fifo.sv
// Byte ring buffer: writes up to MAX_REQ bytes and reads up to GET_MAX
// bytes per cycle. Assumes DEPTH is a power of two and callers never
// overfill or over-read (enforced by credit and get_ok upstream).
module pf_byte_fifo #(
    parameter int DEPTH   = 32,
    parameter int MAX_REQ = 4,
    parameter int GET_MAX = 4,
    parameter int SZ_W    = 3,
    parameter int GL_W    = 3,
    parameter int CNT_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SZ_W-1:0]      wr_n,
    input  logic [MAX_REQ*8-1:0] wr_data,
    input  logic [GL_W-1:0]      rd_n,
    output logic [CNT_W-1:0]     count,
    output logic [GET_MAX*8-1:0] rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt_q;

    // Present the oldest GET_MAX bytes.
    always_comb begin
        for (int i = 0; i < GET_MAX; i++)
            rd_data[i*8 +: 8] = mem[rptr + PTR_W'(i)];
    end

    // Store incoming bytes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_REQ; i++)
            if (SZ_W'(i) < wr_n) mem[wptr + PTR_W'(i)] <= wr_data[i*8 +: 8];
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            wptr  <= wptr + PTR_W'(wr_n);
            rptr  <= rptr + PTR_W'(rd_n);
            cnt_q <= cnt_q + CNT_W'(wr_n) - CNT_W'(rd_n);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/rd_prefetch_fifo.sv
// Read-ahead byte stream buffer top: credit-gated request issue, in-order
// retirement into a byte FIFO, consumer reads, stop/quiesce and status
// pulses. Assumes the memory side completes only issued, busy tags.
module rd_prefetch_fifo #(
    parameter int ADDR_W  = pf_pkg::DEF_ADDR_W,
    parameter int MAX_REQ = pf_pkg::DEF_MAX_REQ,
    parameter int SLOTS   = pf_pkg::DEF_SLOTS,
    parameter int DEPTH   = pf_pkg::DEF_DEPTH,
    parameter int GET_MAX = pf_pkg::DEF_GET_MAX,
    localparam int SZ_W   = $clog2(MAX_REQ + 1),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int PCNT_W = $clog2(SLOTS + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int GL_W   = $clog2(GET_MAX + 1),
    localparam int PB_W   = $clog2(SLOTS * MAX_REQ + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_start,
    input  logic [ADDR_W-1:0]    fill_addr,
    input  logic [ADDR_W-1:0]    fill_len,
    input  logic                 fill_stop,
    input  logic                 drain_req,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [SZ_W-1:0]      req_size,
    output logic [SLOT_W-1:0]    req_slot,
    input  logic                 cpl_valid,
    input  logic [SLOT_W-1:0]    cpl_slot,
    input  logic [MAX_REQ*8-1:0] cpl_data,
    input  logic                 get_valid,
    input  logic [GL_W-1:0]      get_len,
    input  logic                 get_force,
    output logic                 get_ok,
    output logic [GET_MAX*8-1:0] get_data,
    output logic [CNT_W-1:0]     avail,
    output logic                 fill_ended,
    output logic                 eob,
    output logic                 idle,
    output logic                 drained,
    output logic                 underrun
);
    logic                 issue, at_end_nxt, has_free, retire, ret_keep, credit_ok;
    logic [PCNT_W-1:0]    pend_cnt, pend_cnt_nxt;
    logic [PB_W-1:0]      pend_bytes;
    logic [SZ_W-1:0]      ret_size, wr_n;
    logic [MAX_REQ*8-1:0] ret_data;
    logic [GL_W-1:0]      rd_n;
    logic [31:0]          need;

    pf_fill_ctrl #(.ADDR_W(ADDR_W), .MAX_REQ(MAX_REQ), .SZ_W(SZ_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(fill_start), .start_addr(fill_addr),
        .start_len(fill_len), .stop(fill_stop), .issue(issue),
        .next_addr(req_addr), .req_size(req_size), .at_end(fill_ended),
        .at_end_nxt(at_end_nxt)
    );

    pf_slot_track #(.SLOTS(SLOTS), .MAX_REQ(MAX_REQ), .SZ_W(SZ_W), .SLOT_W(SLOT_W),
                    .PCNT_W(PCNT_W), .PB_W(PB_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .issue(issue), .issue_size(req_size),
        .cancel_all(fill_stop), .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
        .cpl_data(cpl_data), .iss_slot(req_slot), .has_free(has_free),
        .pend_cnt(pend_cnt), .pend_cnt_nxt(pend_cnt_nxt), .pend_bytes(pend_bytes),
        .retire(retire), .ret_size(ret_size), .ret_keep(ret_keep), .ret_data(ret_data)
    );

    pf_byte_fifo #(.DEPTH(DEPTH), .MAX_REQ(MAX_REQ), .GET_MAX(GET_MAX), .SZ_W(SZ_W),
                   .GL_W(GL_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_data(ret_data), .rd_n(rd_n),
        .count(avail), .rd_data(get_data)
    );

    // Credit test, issue gating and consumer handshake.
    always_comb begin
        need      = 32'(avail) + 32'(pend_bytes) + 32'(req_size);
        credit_ok = (need <= 32'(DEPTH));
        req_valid = has_free && !fill_ended && credit_ok && !drain_req && !fill_stop;
        issue     = req_valid && req_ready;
        get_ok    = get_valid && (32'(get_len) <= 32'(avail));
        rd_n      = get_ok ? get_len : '0;
        wr_n      = (retire && ret_keep) ? ret_size : '0;
        drained   = (pend_cnt == '0);
    end

    // Registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eob      <= 1'b0;
            idle     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            eob      <= !fill_ended && at_end_nxt;
            idle     <= retire && (pend_cnt_nxt == '0) && at_end_nxt;
            underrun <= get_valid && get_force && !get_ok;
        end
    end
endmodule

// File: rtl/pf_checker.sv
// Property checker for the read-ahead buffer, bound to the top module.
// Assumes the same parameter values as the instance it is bound to.
module pf_checker #(
    parameter int MAX_REQ = 4,
    parameter int SLOTS   = 4,
    parameter int DEPTH   = 32,
    parameter int SZ_W    = 3,
    parameter int GL_W    = 3,
    parameter int CNT_W   = 6,
    parameter int PCNT_W  = 3,
    parameter int PB_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SZ_W-1:0]   req_size,
    input logic              fill_ended,
    input logic              fill_stop,
    input logic              drain_req,
    input logic              drained,
    input logic              eob,
    input logic              idle,
    input logic              underrun,
    input logic              get_valid,
    input logic              get_force,
    input logic [GL_W-1:0]   get_len,
    input logic [CNT_W-1:0]  avail,
    input logic [PB_W-1:0]   pend_bytes,
    input logic [PCNT_W-1:0] pend_cnt
);
    assert_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(avail) + 32'(pend_bytes) <= 32'(DEPTH)));
    assert_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt <= PCNT_W'(SLOTS)));
    assert_ended_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ended |-> !req_valid);
    assert_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_size != '0 && req_size <= SZ_W'(MAX_REQ)));
    assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_stop |=> fill_ended);
    assert_eob_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eob |-> fill_ended);
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && drained) |=> drained);
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> drained);
    assert_underrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (get_valid && get_force && (32'(get_len) > 32'(avail))) |=> underrun);
endmodule

bind rd_prefetch_fifo pf_checker #(
    .MAX_REQ(MAX_REQ), .SLOTS(SLOTS), .DEPTH(DEPTH), .SZ_W(SZ_W), .GL_W(GL_W),
    .CNT_W(CNT_W), .PCNT_W(PCNT_W), .PB_W(PB_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .fill_ended(fill_ended), .fill_stop(fill_stop), .drain_req(drain_req),
    .drained(drained), .eob(eob), .idle(idle), .underrun(underrun),
    .get_valid(get_valid), .get_force(get_force), .get_len(get_len),
    .avail(avail), .pend_bytes(pend_bytes), .pend_cnt(pend_cnt)
);

// File: tb/rd_prefetch_fifo_test.sv
module rd_prefetch_fifo_test;
    localparam int AW = 16, MR = 4, NS = 4, DP = 32, GM = 4;
    localparam int SZW = 3, SLW = 2, GLW = 3, CNTW = 6;

    // Table: base address, length, consumer read size
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{16'h0010, 16, 4}, '{16'h0123, 7, 1}, '{16'h1FFE, 37, 3},
        '{16'h0400, 4, 4},  '{16'h0041, 1, 2}, '{16'h0800, 64, 4}
    };

    logic clk = 0, rst_n = 0;
    logic fill_start = 0, fill_stop = 0, drain_req = 0;
    logic [AW-1:0] fill_addr = '0, fill_len = '0;
    logic req_valid, req_ready = 1;
    logic [AW-1:0] req_addr;
    logic [SZW-1:0] req_size;
    logic [SLW-1:0] req_slot;
    logic cpl_valid = 0;
    logic [SLW-1:0] cpl_slot = '0;
    logic [MR*8-1:0] cpl_data = '0;
    logic get_valid = 0, get_force = 0;
    logic [GLW-1:0] get_len = '0;
    logic get_ok;
    logic [GM*8-1:0] get_data;
    logic [CNTW-1:0] avail;
    logic fill_ended, eob, idle, drained, underrun;

    rd_prefetch_fifo uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int rec_cnt = 0, rsp_cnt = 0, eob_cnt = 0, idle_cnt = 0, und_cnt = 0;
    logic [AW-1:0] rec_addr [256];
    int            rec_size [256];
    logic [SLW-1:0] rec_slot [256];
    bit auto_rsp = 0;
    bit gok;
    logic [GM*8-1:0] gdata;

    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [MR*8-1:0] mk_data(input logic [AW-1:0] a);
        logic [MR*8-1:0] d;
        for (int i = 0; i < MR; i++) d[i*8 +: 8] = mb(a + AW'(i));
        return d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock cycle; inputs are already set (at posedge+2)
    task automatic cyc();
        if (auto_rsp && rsp_cnt < rec_cnt) begin
            cpl_valid = 1;
            cpl_slot  = rec_slot[rsp_cnt];
            cpl_data  = mk_data(rec_addr[rsp_cnt]);
            rsp_cnt++;
        end
        #1;
        if (req_valid && req_ready) begin
            rec_addr[rec_cnt] = req_addr;
            rec_size[rec_cnt] = int'(req_size);
            rec_slot[rec_cnt] = req_slot;
            rec_cnt++;
        end
        gok = get_ok;
        gdata = get_data;
        @(posedge clk);
        #2;
        fill_start = 0; fill_stop = 0; cpl_valid = 0; get_valid = 0; get_force = 0;
        if (eob) eob_cnt++;
        if (idle) idle_cnt++;
        if (underrun) und_cnt++;
    endtask

    task automatic ncyc(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic start_fill(input int a, input int l);
        fill_addr = AW'(a); fill_len = AW'(l); fill_start = 1;
        cyc();
    endtask

    // Consume n bytes in chunks of gl, comparing against address order
    task automatic read_cmp(input int n, input int a0, input int gl, output int bad, output int got);
        bad = 0; got = 0;
        for (int g = 0; g < 3000 && got < n; g++) begin
            int l;
            l = (n - got < gl) ? n - got : gl;
            get_valid = 1; get_len = GLW'(l);
            cyc();
            if (gok) begin
                for (int b = 0; b < l; b++)
                    if (gdata[b*8 +: 8] != mb(AW'(a0 + got + b))) bad++;
                got += l;
            end
        end
    endtask

    // Stop, let in-flight work return, empty the FIFO, clear records
    task automatic flush();
        auto_rsp = 1; fill_stop = 1; cyc();
        ncyc(10);
        for (int g = 0; g < 100 && avail != 0; g++) begin
            get_valid = 1; get_len = (avail >= GM) ? GLW'(GM) : GLW'(avail);
            cyc();
        end
        for (int g = 0; g < 100 && !drained; g++) cyc();
        rec_cnt = 0; rsp_cnt = 0;
    endtask

    initial begin
        int bad, got, nreq, badreq;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R11 reset state
        chk("R11 req_valid", int'(req_valid), 0);
        chk("R11 avail", int'(avail), 0);
        chk("R11 drained", int'(drained), 1);
        chk("R11 fill_ended", int'(fill_ended), 1);
        chk("R11 pulses", int'(eob) + int'(idle) + int'(underrun), 0);

        // Table-driven fills with in-order responder
        for (int v = 0; v < NV; v++) begin
            rec_cnt = 0; rsp_cnt = 0; eob_cnt = 0; idle_cnt = 0; auto_rsp = 1;
            start_fill(VEC[v][0], VEC[v][1]);
            read_cmp(VEC[v][1], VEC[v][0], VEC[v][2], bad, got);
            ncyc(3);
            chk("R5 bytes read", got, VEC[v][1]);
            chk("R5 byte order", bad, 0);
            nreq = (VEC[v][1] + MR - 1) / MR;
            chk("R1 request count", rec_cnt, nreq);
            badreq = 0;
            for (int k = 0; k < rec_cnt; k++) begin
                int rem;
                rem = VEC[v][1] - k * MR;
                if (rec_size[k] != ((rem < MR) ? rem : MR)) badreq++;
                if (rec_addr[k] != AW'(VEC[v][0] + k * MR)) badreq++;
            end
            chk("R1 request addr/size", badreq, 0);
            chk("R7 eob once", eob_cnt, 1);
            chk("R9 idle once", idle_cnt, 1);
            chk("R7 fill_ended", int'(fill_ended), 1);
        end

        // R2 slot limit, then credit limit
        rec_cnt = 0; rsp_cnt = 0; auto_rsp = 0;
        start_fill(16'h1000, 64);
        ncyc(6);
        chk("R2 slot limit", rec_cnt, NS);
        chk("R8 not drained", int'(drained), 0);
        auto_rsp = 1;
        ncyc(20);
        chk("R2 credit issue", rec_cnt, 8);
        chk("R2 fifo full", int'(avail), DP);
        ncyc(5);
        chk("R2 credit hold", rec_cnt, 8);
        read_cmp(4, 16'h1000, 4, bad, got);
        chk("R5 head bytes", bad, 0);
        ncyc(4);
        chk("R5 issue after read", rec_cnt, 9);
        fill_stop = 1; cyc(); ncyc(4);
        read_cmp(32, 16'h1004, 4, bad, got);
        chk("R5 remaining bytes", got + bad * 1000, 32);
        flush();

        // R10 underrun on empty FIFO
        und_cnt = 0;
        get_valid = 1; get_len = 2; get_force = 0; cyc();
        chk("R5 fail when short", int'(gok), 0);
        chk("R10 no flag unforced", und_cnt, 0);
        get_valid = 1; get_len = 2; get_force = 1; cyc();
        chk("R10 forced underrun", und_cnt, 1);
        chk("R10 avail unchanged", int'(avail), 0);

        // R4 stop voids in-flight reads
        rec_cnt = 0; rsp_cnt = 0; auto_rsp = 0;
        start_fill(16'h2000, 40);
        ncyc(6);
        eob_cnt = 0; idle_cnt = 0;
        fill_stop = 1; cyc();
        chk("R4 no issue on stop", rec_cnt, NS);
        chk("R4 ended after stop", int'(fill_ended), 1);
        chk("R7 eob on stop", eob_cnt, 1);
        auto_rsp = 1;
        ncyc(10);
        chk("R4 void data dropped", int'(avail), 0);
        chk("R4 no new request", rec_cnt, NS);
        chk("R8 drained after stop", int'(drained), 1);
        chk("R9 idle after stop", idle_cnt, 1);
        rec_cnt = 0; rsp_cnt = 0;
        start_fill(16'h3000, 4);
        ncyc(6);
        chk("R4 refill avail", int'(avail), 4);
        read_cmp(4, 16'h3000, 4, bad, got);
        chk("R4 refill bytes", bad, 0);

        // R6 start ignored mid-fill
        rec_cnt = 0; rsp_cnt = 0; auto_rsp = 0;
        start_fill(16'h4000, 40);
        ncyc(6);
        start_fill(16'h8000, 4);
        auto_rsp = 1;
        ncyc(10);
        chk("R6 fill continues", int'(rec_addr[4]), 16'h4010);
        chk("R6 requests beyond four", int'(rec_cnt > 4), 1);
        flush();

        // R8 quiesce holds issue
        rec_cnt = 0; rsp_cnt = 0; auto_rsp = 0;
        drain_req = 1;
        start_fill(16'h5000, 8);
        ncyc(5);
        chk("R8 no issue while quiesced", rec_cnt, 0);
        chk("R8 drained while quiesced", int'(drained), 1);
        drain_req = 0;
        ncyc(3);
        chk("R8 issue after release", rec_cnt, 2);
        chk("R8 busy after release", int'(drained), 0);
        auto_rsp = 1;
        ncyc(5);
        chk("R8 drained at end", int'(drained), 1);
        chk("R8 data present", int'(avail), 8);
        flush();

        // R3 out-of-order completion, in-order retirement
        rec_cnt = 0; rsp_cnt = 0; auto_rsp = 0;
        start_fill(16'h6000, 8);
        ncyc(4);
        chk("R3 two requests", rec_cnt, 2);
        cpl_valid = 1; cpl_slot = rec_slot[1]; cpl_data = mk_data(rec_addr[1]); cyc();
        ncyc(3);
        chk("R3 later tag held", int'(avail), 0);
        cpl_valid = 1; cpl_slot = rec_slot[0]; cpl_data = mk_data(rec_addr[0]); cyc();
        ncyc(4);
        chk("R3 both retired", int'(avail), 8);
        read_cmp(8, 16'h6000, 4, bad, got);
        chk("R3 retirement order", bad, 0);
        rsp_cnt = rec_cnt;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule